// File: doc/BRIEF.md
# Torus Dimension Switch with Virtual Channels

One instance of this block routes flits along a single dimension of a torus network. Three switches are chained per node, one per dimension: the node's injection traffic enters the first switch's turn-in port, each switch's turn-out feeds the next switch's turn-in, and the turn-out of the last switch delivers to the node. Every switch has three inputs (turn-in, plus link, minus link) and three outputs (turn-out, plus, minus). Port index 0 is the turn port, 1 is plus, 2 is minus, on both sides.

Each input holds one buffer of `DEPTH` flits per virtual channel. A flit is `PAYLOAD_W+2` bits: bit `PAYLOAD_W+1` marks a header, bit `PAYLOAD_W` marks the last flit of a packet, and the low `PAYLOAD_W` bits are data. A header carries one `COORD_W`-bit coordinate per dimension; this switch reads the field at bits `[DIM*COORD_W +: COORD_W]`. A packet whose coordinate equals the switch's own leaves on the turn port, otherwise it travels the shorter way around the `2**COORD_W`-node ring. A packet keeps its virtual channel number on the way out.

Each output runs a small state machine with states IDLE and LINKED. In IDLE, the GRANT transition picks one requesting input/VC header and records it as owner; in LINKED, the output forwards the owner's flits whenever the downstream VC reports space, and the RELEASE transition returns to IDLE in the cycle the last flit leaves. Winners are chosen by distance from a per-output input pointer and VC pointer, which move to one past the winner on every GRANT. Each input VC drives a level OK signal back upstream while its buffer has a free slot.

Top module: `dim_switch`

## Requirements
- R1: After reset, every `out_valid` bit is 0 and every `in_ok` bit is 1.
- R2: `in_ok[p*NUM_VC+v]` is 1 exactly when the buffer for input p, VC v holds fewer than `DEPTH` (8) flits; a buffer holds 8 flits without loss.
- R3: A header whose coordinate field equals `my_coord` leaves on output 0 (turn).
- R4: Otherwise, with d = (dest - my_coord) mod 16, d in 1..8 goes to output 1 (plus) and d in 9..15 to output 2 (minus); d = 8 takes plus.
- R5: Only header bits `[DIM*4 +: 4]` (DIM = 1: bits 7:4) steer routing; the other coordinate fields have no effect.
- R6: Once granted, an output carries every flit of the packet in order on the same VC up to and including the last flit, with no other flit interleaved, and then returns to IDLE.
- R7: An output sends a flit on VC v only in a cycle after which `out_ok[o*NUM_VC+v]` was 1 at the sending edge; while it is 0 the output holds, and resumes without loss when it rises.
- R8: Among waiting headers, the winner has the smallest ((i - in_ptr) mod 3) * NUM_VC + ((v - vc_ptr) mod NUM_VC); both pointers start at 0.
- R9: After a GRANT to input i, VC v, the input pointer becomes (i+1) mod 3 and the VC pointer (v+1) mod NUM_VC.
- R10: A VC waiting on a blocked output does not stop another VC of the same input from using a different free output.
- R11: A header written at clock edge k reaches a free, unblocked output so that `out_valid` is 1 after edge k+2 and 0 after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_coord | input | COORD_W | This switch's coordinate in its dimension |
| in_valid | input | 3 | Flit present on each input |
| in_vc | input | 3*VC_W | VC number per input |
| in_flit | input | 3*(PAYLOAD_W+2) | Flit per input |
| in_ok | output | 3*NUM_VC | Per input VC: buffer has a free slot |
| out_valid | output | 3 | Flit present on each output |
| out_vc | output | 3*VC_W | VC number per output |
| out_flit | output | 3*(PAYLOAD_W+2) | Flit per output |
| out_ok | input | 3*NUM_VC | Per output VC: downstream has space |

## Verification
Routing is tried with a table of coordinate/destination pairs that cover a match, each side of the half-ring boundary, the exact tie, and wrap across zero, with the unused coordinate fields set to values that would route differently if decoded. Arbitration is tried with simultaneous headers whose input-major and VC-major orderings disagree, and with headers queued behind a held multi-flit packet, so the order seen at the output separates a rotating pointer from a fixed index priority. Blocking patterns hold one downstream VC low to tell a stalled link apart from a lost or reordered flit, and to show that another VC of the same input still reaches a different output.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    localparam int NPORT = 3;

    typedef enum logic [1:0] {
        DIR_TURN  = 2'd0,
        DIR_PLUS  = 2'd1,
        DIR_MINUS = 2'd2
    } dir_e;

    typedef enum logic {
        ARB_IDLE   = 1'b0,
        ARB_LINKED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dsw_vc_fifo.sv
module dsw_vc_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/dsw_route.sv
module dsw_route
    import dsw_pkg::*;
#(
    parameter int PAYLOAD_W = 16,
    parameter int COORD_W   = 4,
    parameter int DIM       = 1
) (
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic [COORD_W-1:0]   my_coord,
    output dir_e                 dir
);
    localparam logic [COORD_W-1:0] HALF = COORD_W'(1) << (COORD_W - 1);

    logic [COORD_W-1:0] dest;
    logic [COORD_W-1:0] hops;

    assign dest = payload[DIM*COORD_W +: COORD_W];
    assign hops = dest - my_coord;

    always_comb begin
        if (hops == '0) begin
            dir = DIR_TURN;
        end else if (hops <= HALF) begin
            dir = DIR_PLUS;
        end else begin
            dir = DIR_MINUS;
        end
    end

endmodule

// File: rtl/dsw_out_arb.sv
module dsw_out_arb
    import dsw_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2,
    parameter int PW     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT*NUM_VC-1:0] req,
    input  logic                    owner_avail,
    input  logic                    owner_tail,
    input  logic [NUM_VC-1:0]       dn_ok,
    output logic                    linked,
    output logic [PW-1:0]           owner_in,
    output logic [VC_W-1:0]         owner_vc,
    output logic                    send
);
    arb_state_e      state_q, state_d;
    logic [PW-1:0]   ip_pri;
    logic [VC_W-1:0] vc_pri;
    logic            pick_valid;
    logic [PW-1:0]   pick_in;
    logic [VC_W-1:0] pick_vc;

    // Rotating-distance pick: input distance is the major key.
    always_comb begin
        int best_d;
        int d;
        pick_valid = 1'b0;
        pick_in    = '0;
        pick_vc    = '0;
        best_d     = NPORT * NUM_VC;
        for (int i = 0; i < NPORT; i++) begin
            for (int v = 0; v < NUM_VC; v++) begin
                d = ((i + NPORT - int'(ip_pri)) % NPORT) * NUM_VC
                  + ((v + NUM_VC - int'(vc_pri)) % NUM_VC);
                if (req[i*NUM_VC + v] && (d < best_d)) begin
                    best_d     = d;
                    pick_valid = 1'b1;
                    pick_in    = PW'(i);
                    pick_vc    = VC_W'(v);
                end
            end
        end
    end

    // Next state: GRANT and RELEASE transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:   if (pick_valid)            state_d = ARB_LINKED;
            ARB_LINKED: if (send && owner_tail)    state_d = ARB_IDLE;
            default:                               state_d = ARB_IDLE;
        endcase
    end

    // State register and owner/pointer record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ARB_IDLE;
            owner_in <= '0;
            owner_vc <= '0;
            ip_pri   <= '0;
            vc_pri   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && pick_valid) begin
                owner_in <= pick_in;
                owner_vc <= pick_vc;
                ip_pri   <= (pick_in == PW'(NPORT - 1)) ? '0 : pick_in + 1'b1;
                vc_pri   <= (pick_vc == VC_W'(NUM_VC - 1)) ? '0 : pick_vc + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        linked = (state_q == ARB_LINKED);
        send   = (state_q == ARB_LINKED) && owner_avail && dn_ok[owner_vc];
    end

    assert_hold_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && !(send && owner_tail)) |=>
            (linked && $stable(owner_in) && $stable(owner_vc)));

    assert_release_on_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && send && owner_tail) |=> !linked);

    assert_grant_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!linked && !(|req)) |=> !linked);

endmodule

// File: rtl/dim_switch.sv
module dim_switch
    import dsw_pkg::*;
#(
    parameter int NUM_VC    = 4,
    parameter int DEPTH     = 8,
    parameter int PAYLOAD_W = 16,
    parameter int COORD_W   = 4,
    parameter int DIM       = 1,
    parameter int VC_W      = $clog2(NUM_VC),
    parameter int FLIT_W    = PAYLOAD_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COORD_W-1:0]      my_coord,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*VC_W-1:0]   in_vc,
    input  logic [NPORT*FLIT_W-1:0] in_flit,
    output logic [NPORT*NUM_VC-1:0] in_ok,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*VC_W-1:0]   out_vc,
    output logic [NPORT*FLIT_W-1:0] out_flit,
    input  logic [NPORT*NUM_VC-1:0] out_ok
);
    localparam int NQ       = NPORT * NUM_VC;
    localparam int QW       = $clog2(NQ);
    localparam int PW       = $clog2(NPORT);
    localparam int HEAD_BIT = PAYLOAD_W + 1;
    localparam int TAIL_BIT = PAYLOAD_W;

    logic [FLIT_W-1:0] q_head  [NQ];
    logic [NQ-1:0]     q_empty;
    logic [NQ-1:0]     q_full;
    logic [NQ-1:0]     q_push;
    logic [NQ-1:0]     q_pop;
    logic [NQ-1:0]     q_busy;
    dir_e              q_dir   [NQ];

    logic [NQ-1:0]     arb_req [NPORT];
    logic [NPORT-1:0]  arb_linked;
    logic [NPORT-1:0]  arb_send;
    logic [NPORT-1:0]  own_avail;
    logic [NPORT-1:0]  own_tail;
    logic [PW-1:0]     own_in  [NPORT];
    logic [VC_W-1:0]   own_vc  [NPORT];
    logic [QW-1:0]     own_idx [NPORT];

    logic [NPORT-1:0]  out_valid_q;
    logic [VC_W-1:0]   out_vc_q   [NPORT];
    logic [FLIT_W-1:0] out_flit_q [NPORT];

    // Per input/VC buffers and route decode.
    for (genvar i = 0; i < NPORT; i++) begin : g_in
        for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
            localparam int Q = i * NUM_VC + v;

            assign q_push[Q] = in_valid[i] && (in_vc[i*VC_W +: VC_W] == VC_W'(v));

            dsw_vc_fifo #(
                .DEPTH (DEPTH),
                .W     (FLIT_W)
            ) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (q_push[Q]),
                .din   (in_flit[i*FLIT_W +: FLIT_W]),
                .pop   (q_pop[Q]),
                .dout  (q_head[Q]),
                .empty (q_empty[Q]),
                .full  (q_full[Q])
            );

            dsw_route #(
                .PAYLOAD_W (PAYLOAD_W),
                .COORD_W   (COORD_W),
                .DIM       (DIM)
            ) u_route (
                .payload  (q_head[Q][PAYLOAD_W-1:0]),
                .my_coord (my_coord),
                .dir      (q_dir[Q])
            );
        end
    end

    assign in_ok = ~q_full;

    // Requests per output: a waiting header not already linked elsewhere.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int q = 0; q < NQ; q++) begin
                arb_req[o][q] = !q_empty[q] && q_head[q][HEAD_BIT] && !q_busy[q]
                             && (q_dir[q] == dir_e'(o));
            end
        end
    end

    // Owner lookup for each output.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            own_idx[o]   = QW'(int'(own_in[o]) * NUM_VC + int'(own_vc[o]));
            own_avail[o] = !q_empty[own_idx[o]];
            own_tail[o]  = q_head[own_idx[o]][TAIL_BIT];
        end
    end

    // Busy (linked) and pop per input VC.
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            q_busy[q] = 1'b0;
            q_pop[q]  = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                if (arb_linked[o] && own_idx[o] == QW'(q)) q_busy[q] = 1'b1;
                if (arb_send[o]   && own_idx[o] == QW'(q)) q_pop[q]  = 1'b1;
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        dsw_out_arb #(
            .NUM_VC (NUM_VC),
            .VC_W   (VC_W),
            .PW     (PW)
        ) u_arb (
            .clk         (clk),
            .rst_n       (rst_n),
            .req         (arb_req[o]),
            .owner_avail (own_avail[o]),
            .owner_tail  (own_tail[o]),
            .dn_ok       (out_ok[o*NUM_VC +: NUM_VC]),
            .linked      (arb_linked[o]),
            .owner_in    (own_in[o]),
            .owner_vc    (own_vc[o]),
            .send        (arb_send[o])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid_q[o] <= 1'b0;
                out_vc_q[o]    <= '0;
                out_flit_q[o]  <= '0;
            end else begin
                out_valid_q[o] <= arb_send[o];
                if (arb_send[o]) begin
                    out_vc_q[o]   <= own_vc[o];
                    out_flit_q[o] <= q_head[own_idx[o]];
                end
            end
        end

        assign out_valid[o]                 = out_valid_q[o];
        assign out_vc[o*VC_W +: VC_W]       = out_vc_q[o];
        assign out_flit[o*FLIT_W +: FLIT_W] = out_flit_q[o];
    end

    // Checker state: downstream OK as seen at the previous edge.
    logic [NQ-1:0] chk_ok_d;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_ok_d <= '0;
        else        chk_ok_d <= out_ok;
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_chk
        assert_send_after_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_q[o] |-> chk_ok_d[o*NUM_VC + int'(out_vc_q[o])]);
    end

    assert_turn_matches_coord_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q[0] && out_flit_q[0][HEAD_BIT]) |->
            (out_flit_q[0][DIM*COORD_W +: COORD_W] == my_coord));

endmodule

// File: tb/dim_switch_tb_top.sv
module dim_switch_tb_top;

    localparam int NP  = 3;
    localparam int NV  = 4;
    localparam int VW  = 2;
    localparam int FW  = 18;
    localparam int LOGN = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      my_coord = 4'd0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP*VW-1:0] in_vc = '0;
    logic [NP*FW-1:0] in_flit = '0;
    logic [NP*NV-1:0] in_ok;
    logic [NP-1:0]   out_valid;
    logic [NP*VW-1:0] out_vc;
    logic [NP*FW-1:0] out_flit;
    logic [NP*NV-1:0] out_ok = '1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10ns clk = ~clk;

    dim_switch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .my_coord  (my_coord),
        .in_valid  (in_valid),
        .in_vc     (in_vc),
        .in_flit   (in_flit),
        .in_ok     (in_ok),
        .out_valid (out_valid),
        .out_vc    (out_vc),
        .out_flit  (out_flit),
        .out_ok    (out_ok)
    );

    // Output log, filled at the falling edge.
    logic [FW-1:0] log_flit [NP][LOGN];
    logic [VW-1:0] log_vc   [NP][LOGN];
    int            log_n    [NP];

    initial for (int o = 0; o < NP; o++) log_n[o] = 0;

    always @(negedge clk) begin
        for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && log_n[o] < LOGN) begin
                log_flit[o][log_n[o]] = out_flit[o*FW +: FW];
                log_vc[o][log_n[o]]   = out_vc[o*VW +: VW];
                log_n[o]              = log_n[o] + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [3:0] tag, input logic [3:0] dest);
        logic [3:0] noise;
        noise = (dest == my_coord) ? my_coord + 4'd1 : my_coord;
        return {tag, noise, dest, noise};
    endfunction

    task automatic drive(input int p, input int vc, input logic hd, input logic tl,
                         input logic [3:0] tag, input logic [3:0] dest);
        in_valid[p]          = 1'b1;
        in_vc[p*VW +: VW]    = VW'(vc);
        in_flit[p*FW +: FW]  = {hd, tl, mk(tag, dest)};
    endtask

    task automatic step();
        @(negedge clk);
        in_valid = '0;
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = '0;
        out_ok   = '1;
        wait_cycles(3);
        rst_n = 1'b1;
        step();
    endtask

    // Route vectors: {coord, dest, expected output}; 0 turn, 1 plus, 2 minus.
    localparam int NROUTE = 14;
    localparam logic [11:0] ROUTE_VEC [NROUTE] = '{
        {4'd5,  4'd5,  4'd0},
        {4'd0,  4'd0,  4'd0},
        {4'd15, 4'd15, 4'd0},
        {4'd5,  4'd6,  4'd1},
        {4'd5,  4'd12, 4'd1},
        {4'd5,  4'd13, 4'd1},
        {4'd5,  4'd14, 4'd2},
        {4'd5,  4'd4,  4'd2},
        {4'd15, 4'd0,  4'd1},
        {4'd0,  4'd15, 4'd2},
        {4'd0,  4'd8,  4'd1},
        {4'd3,  4'd11, 4'd1},
        {4'd12, 4'd3,  4'd1},
        {4'd12, 4'd5,  4'd2}
    };

    initial begin
        int base [NP];

        do_reset();
        // R1: reset state
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "in_ok after reset", int'(in_ok), 4095);

        // Route table walk (R3, R4, R5)
        for (int r = 0; r < NROUTE; r++) begin
            logic [3:0] c, d, e;
            {c, d, e} = ROUTE_VEC[r];
            my_coord = c;
            for (int o = 0; o < NP; o++) base[o] = log_n[o];
            drive(0, 0, 1'b1, 1'b1, 4'(r), d);
            step();
            wait_cycles(4);
            for (int o = 0; o < NP; o++) begin
                check((e == 0) ? "R3" : "R4_R5",
                      $sformatf("row %0d output %0d count", r, o),
                      log_n[o] - base[o], (o == int'(e)) ? 1 : 0);
            end
        end

        // R11: latency
        do_reset();
        my_coord = 4'd5;
        drive(0, 0, 1'b1, 1'b1, 4'd1, 4'd7);
        step();
        check("R11", "plus valid after edge k", int'(out_valid[1]), 0);
        step();
        check("R11", "plus valid after edge k+1", int'(out_valid[1]), 0);
        step();
        check("R11", "plus valid after edge k+2", int'(out_valid[1]), 1);

        // R8: input distance is the major key
        do_reset();
        for (int o = 0; o < NP; o++) base[o] = log_n[o];
        drive(0, 3, 1'b1, 1'b1, 4'd1, 4'd5);
        drive(1, 0, 1'b1, 1'b1, 4'd2, 4'd5);
        drive(2, 1, 1'b1, 1'b1, 4'd3, 4'd5);
        step();
        wait_cycles(10);
        check("R8", "turn count", log_n[0] - base[0], 3);
        for (int k = 0; k < 3; k++)
            check("R8", $sformatf("grant order tag %0d", k),
                  int'(log_flit[0][base[0] + k][15:12]), k + 1);

        // R6 and R9: held packet, then pointer-based pick
        do_reset();
        for (int o = 0; o < NP; o++) base[o] = log_n[o];
        drive(1, 1, 1'b1, 1'b0, 4'd1, 4'd5);
        step();
        drive(1, 1, 1'b0, 1'b0, 4'd2, 4'd5);
        drive(0, 0, 1'b1, 1'b1, 4'd3, 4'd5);
        step();
        drive(0, 3, 1'b1, 1'b1, 4'd4, 4'd5);
        step();
        wait_cycles(3);
        check("R6", "no interleave while packet open", log_n[0] - base[0], 2);
        drive(1, 1, 1'b0, 1'b1, 4'd5, 4'd5);
        step();
        wait_cycles(10);
        check("R6", "turn count", log_n[0] - base[0], 5);
        check("R6", "flit 0 tag", int'(log_flit[0][base[0]][15:12]), 1);
        check("R6", "flit 1 tag", int'(log_flit[0][base[0] + 1][15:12]), 2);
        check("R6", "flit 2 tag", int'(log_flit[0][base[0] + 2][15:12]), 5);
        check("R6", "packet VC kept", int'(log_vc[0][base[0] + 2]), 1);
        check("R9", "after rotation VC3 first", int'(log_flit[0][base[0] + 3][15:12]), 4);
        check("R9", "VC0 last", int'(log_flit[0][base[0] + 4][15:12]), 3);

        // R2: buffer fill and OK
        do_reset();
        out_ok[0*NV + 1] = 1'b0;
        for (int o = 0; o < NP; o++) base[o] = log_n[o];
        for (int k = 0; k < 8; k++) begin
            drive(2, 1, (k == 0), (k == 7), 4'(k), 4'd5);
            step();
            if (k == 6) check("R2", "ok with 7 flits", int'(in_ok[2*NV + 1]), 1);
        end
        check("R2", "ok with 8 flits", int'(in_ok[2*NV + 1]), 0);
        check("R2", "neighbour VC ok", int'(in_ok[2*NV + 0]), 1);
        check("R7", "no send while blocked", log_n[0] - base[0], 0);
        out_ok[0*NV + 1] = 1'b1;
        wait_cycles(12);
        check("R2", "all 8 drained", log_n[0] - base[0], 8);
        begin
            int ord_ok = 1;
            for (int k = 0; k < 8; k++)
                if (int'(log_flit[0][base[0] + k][15:12]) != k) ord_ok = 0;
            check("R2", "drain order", ord_ok, 1);
        end
        check("R2", "ok restored", int'(in_ok[2*NV + 1]), 1);

        // R7 and R10: blocked plus, other VC to minus
        do_reset();
        out_ok[1*NV + 2] = 1'b0;
        for (int o = 0; o < NP; o++) base[o] = log_n[o];
        drive(0, 2, 1'b1, 1'b1, 4'd1, 4'd7);
        step();
        drive(0, 3, 1'b1, 1'b1, 4'd2, 4'd3);
        step();
        wait_cycles(5);
        check("R7", "plus held", log_n[1] - base[1], 0);
        check("R10", "minus passed", log_n[2] - base[2], 1);
        check("R10", "minus VC", int'(log_vc[2][base[2]]), 3);
        out_ok[1*NV + 2] = 1'b1;
        step();
        check("R7", "plus resumes", int'(out_valid[1]), 1);
        check("R7", "plus VC", int'(out_vc[1*VW +: VW]), 2);
        step();

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(100000 * 20ns);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule